// File: doc/BRIEF.md
# Smart-Card Byte Transmitter with Automatic Resend

This block sends bytes over a single open-drain serial line. It uses the character format common to contact smart cards. The host or a DMA engine writes a byte into a one-entry holding register. The block then sends a start bit, the eight data bits least significant first, and an even parity bit. After that it releases the line for two guard units. In the first guard unit it listens for a receiver that pulls the line low to reject the character. A rejected character is resent from the holding register without any help from the host. The next resend begins once the line has been high for two full units. Retries have no limit.

The host sees three flags. The holding-empty flag and the transmit-end flag always rise together, and only when a character has been accepted. So a DMA request driven from the transmit-end interrupt is not raised during a retry. The error flag is sticky and only software clears it. Each interrupt output is its flag gated by an enable input. A programmable divider sets the length of one elementary time unit (ETU) in clock cycles.

Top module: `sc_tx_retry`

## Requirements
- R1: After reset `hold_empty` = 1, `tx_end` = 1, `err_flag` = 0 and `io_drive_low` = 0.
- R2: A character on the line is: one start bit (line low), then data bit 0 through data bit 7, then a parity bit equal to the XOR of the eight data bits (even parity). The block drives the line only through `io_drive_low` (1 = pull low, 0 = release), so a 1-bit is sent as release.
- R3: One ETU lasts `etu_div` clock cycles, with `etu_div` of at least 8. Bit k of the character (start = 0, parity = 9) occupies ETU k, and ETU 0 begins on the clock edge that accepts the write.
- R4: During ETU 10 and ETU 11 (the guard units) `io_drive_low` is 0. The line passes through a two-flop synchronizer and is sampled once, at cycle `etu_div/2` of ETU 10. A low level there is an error signal.
- R5: An error signal sets `err_flag`. `err_irq` equals `err_flag` AND `err_ie`.
- R6: After an error signal, `tx_end` and `hold_empty` stay 0. The same byte is sent again. Its start bit begins at the end of the second consecutive ETU in which the line sampled high after the character, which is 2 ETUs after the receiver releases the line.
- R7: When the ETU 10 sample is high, `tx_end` and `hold_empty` both become 1 at the end of ETU 11. `tx_irq` equals `tx_end` AND `tx_ie`.
- R8: A `wr_en` pulse while `hold_empty` = 1 loads `wr_data`, clears `hold_empty` and `tx_end` on the next edge, and starts a character. A `wr_en` while `hold_empty` = 0 has no effect on the byte being sent, and no further character follows.
- R9: `err_flag` is cleared only by `err_clr`, and a set in the same cycle wins. A later successful character leaves `err_flag` unchanged.
- R10: Resending repeats without limit until a character draws no error signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_div | input | DIV_W | Clock cycles per elementary time unit (at least 8) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| err_clr | input | 1 | Clears the sticky error flag |
| tx_ie | input | 1 | Enable for the transmit-end interrupt |
| err_ie | input | 1 | Enable for the error interrupt |
| io_in | input | 1 | Level of the shared I/O line |
| io_drive_low | output | 1 | 1 pulls the open-drain line low |
| hold_empty | output | 1 | Holding register free for a new byte |
| tx_end | output | 1 | Last byte accepted by the receiver |
| err_flag | output | 1 | Sticky error-signal flag |
| tx_irq | output | 1 | Transmit-end interrupt / DMA request |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench tests the main function with several byte patterns. All-zero and all-one bytes push the parity bit to both values and keep the line low or released for long runs. Random bytes with random dividers show that bit ordering and ETU length hold for any divider value, not just one. Each byte is sent with between zero and three rejections. This separates a correct resend of the original byte from a resend of a byte written while busy. It also tests the exact gap of two ETUs before a resend, and shows that the transmit-end flag is held back through every retry while the sticky error flag survives later good characters.

// File: rtl/sct_pkg.sv
// Shared definitions for the smart-card transmitter.
// Assumes characters of one start bit, DATA_W data bits and one parity bit.
package sct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_GUARD,
        ST_RECOVER
    } sct_state_e;

    // Number of consecutive high ETUs needed before a resend.
    localparam int QUIET_ETUS = 2;
endpackage

// File: rtl/sct_sync2.sv
// Two-flop synchronizer for the asynchronous I/O line level.
// Assumes the line idles at RST_VAL so reset causes no false edge.
module sct_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/sct_etu_timer.sv
// Elementary-time-unit timer: counts div clock cycles per unit.
// Gives a pulse at the unit centre and at its last cycle.
// Assumes div >= 8 and stays stable while run is 1.
module sct_etu_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             etu_mid,
    output logic             etu_last
);
    logic [DIV_W-1:0] cnt_q;

    assign etu_mid  = run && (cnt_q == (div >> 1));
    assign etu_last = run && (cnt_q == div - 1'b1);

    // Cycle counter within the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= etu_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sct_frame_fsm.sv
// Character sequencer: shifts out start, data and parity bits, releases
// the line for two guard units, and samples the error signal in the first
// one. After an error it waits for a quiet line, then reloads load_data
// and sends again.
// Assumes load_data holds the byte for the whole transfer, including retries.
module sct_frame_fsm
    import sct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic              etu_mid,
    input  logic              etu_last,
    input  logic              line_s,
    output logic              busy,
    output logic              drive_low,
    output logic              err_seen,
    output logic              frame_ok
);
    localparam int PAR_IDX = DATA_W + 1;
    localparam int G0_IDX  = DATA_W + 2;
    localparam int G1_IDX  = DATA_W + 3;
    localparam int IDX_W   = $clog2(G1_IDX + 1);

    sct_state_e       state_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic [DATA_W:0]  shreg_q;
    logic             err_hit_q;
    logic [1:0]       hi_cnt_q;
    logic             resend;

    assign busy     = (state_q != ST_IDLE);
    assign err_seen = (state_q == ST_GUARD) && etu_mid &&
                      (bit_idx_q == IDX_W'(G0_IDX)) && !line_s;
    assign frame_ok = (state_q == ST_GUARD) && etu_last &&
                      (bit_idx_q == IDX_W'(G1_IDX)) && !err_hit_q;
    assign resend   = (state_q == ST_RECOVER) && etu_last &&
                      (hi_cnt_q == 2'(QUIET_ETUS));

    // Character state machine and bit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            err_hit_q <= 1'b0;
            hi_cnt_q  <= '0;
            drive_low <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q   <= {^load_data, load_data};
                        bit_idx_q <= '0;
                        drive_low <= 1'b1;
                        err_hit_q <= 1'b0;
                        state_q   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (etu_last) begin
                        if (bit_idx_q == IDX_W'(PAR_IDX)) begin
                            drive_low <= 1'b0;
                            bit_idx_q <= IDX_W'(G0_IDX);
                            state_q   <= ST_GUARD;
                        end else begin
                            drive_low <= ~shreg_q[0];
                            shreg_q   <= shreg_q >> 1;
                            bit_idx_q <= bit_idx_q + 1'b1;
                        end
                    end
                end
                ST_GUARD: begin
                    if (err_seen) begin
                        err_hit_q <= 1'b1;
                    end
                    if (etu_last) begin
                        if (bit_idx_q == IDX_W'(G0_IDX)) begin
                            bit_idx_q <= IDX_W'(G1_IDX);
                        end else if (err_hit_q) begin
                            hi_cnt_q <= '0;
                            state_q  <= ST_RECOVER;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_RECOVER: begin
                    if (etu_mid) begin
                        if (!line_s) begin
                            hi_cnt_q <= '0;
                        end else if (hi_cnt_q != 2'(QUIET_ETUS)) begin
                            hi_cnt_q <= hi_cnt_q + 1'b1;
                        end
                    end
                    if (resend) begin
                        shreg_q   <= {^load_data, load_data};
                        bit_idx_q <= '0;
                        drive_low <= 1'b1;
                        err_hit_q <= 1'b0;
                        state_q   <= ST_SEND;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_tx_retry.sv
// Smart-card transmitter top: holding register, status flags, interrupt
// gating, ETU timer, line synchronizer and character sequencer.
// Assumes etu_div >= 8 and is changed only while tx_end is 1.
module sc_tx_retry #(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  etu_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_clr,
    input  logic              tx_ie,
    input  logic              err_ie,
    input  logic              io_in,
    output logic              io_drive_low,
    output logic              hold_empty,
    output logic              tx_end,
    output logic              err_flag,
    output logic              tx_irq,
    output logic              err_irq
);
    logic [DATA_W-1:0] hold_q;
    logic              accept;
    logic              line_s;
    logic              busy;
    logic              etu_mid;
    logic              etu_last;
    logic              err_seen;
    logic              frame_ok;
    logic [DATA_W-1:0] load_data;

    assign accept    = wr_en && hold_empty;
    assign load_data = hold_empty ? wr_data : hold_q;
    assign tx_irq    = tx_end && tx_ie;
    assign err_irq   = err_flag && err_ie;

    sct_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (io_in),
        .q_sync  (line_s)
    );

    sct_etu_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (busy),
        .div      (etu_div),
        .etu_mid  (etu_mid),
        .etu_last (etu_last)
    );

    sct_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .load_data (load_data),
        .etu_mid   (etu_mid),
        .etu_last  (etu_last),
        .line_s    (line_s),
        .busy      (busy),
        .drive_low (io_drive_low),
        .err_seen  (err_seen),
        .frame_ok  (frame_ok)
    );

    // Holding register and the paired empty / end flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_empty <= 1'b1;
            tx_end     <= 1'b1;
        end else if (accept) begin
            hold_q     <= wr_data;
            hold_empty <= 1'b0;
            tx_end     <= 1'b0;
        end else if (frame_ok) begin
            hold_empty <= 1'b1;
            tx_end     <= 1'b1;
        end
    end

    // Sticky error flag, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_seen) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_tx_retry_chk.sv
// Property checker for sc_tx_retry, attached with bind.
module sc_tx_retry_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic err_clr,
    input logic io_drive_low,
    input logic hold_empty,
    input logic tx_end,
    input logic err_flag
);
    // R7: the two status flags move together.
    assert_flags_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_empty == tx_end);

    // R4: the line is never pulled while no character is pending.
    assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> !io_drive_low);

    // R8: an accepted write clears both flags on the next edge.
    assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> (!hold_empty && !tx_end));

    // R9: the error flag only drops on a software clear.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R6: an error never appears together with transmit-end.
    assert_err_holds_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !tx_end);
endmodule

bind sc_tx_retry sc_tx_retry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .err_clr      (err_clr),
    .io_drive_low (io_drive_low),
    .hold_empty   (hold_empty),
    .tx_end       (tx_end),
    .err_flag     (err_flag)
);

// File: tb/sc_tx_retry_tb.sv
`timescale 1ns/1ps
module sc_tx_retry_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] etu_div = 12'd8;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        err_clr = 1'b0;
    logic        tx_ie = 1'b0;
    logic        err_ie = 1'b0;
    logic        card_pull = 1'b0;
    logic        io_line;
    logic        io_drive_low, hold_empty, tx_end, err_flag, tx_irq, err_irq;

    int total = 0;
    int bad = 0;
    int D = 8;
    bit err_model = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign io_line = !(io_drive_low || card_pull);

    sc_tx_retry u_dut (
        .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .wr_en(wr_en),
        .wr_data(wr_data), .err_clr(err_clr), .tx_ie(tx_ie), .err_ie(err_ie),
        .io_in(io_line), .io_drive_low(io_drive_low), .hold_empty(hold_empty),
        .tx_end(tx_end), .err_flag(err_flag), .tx_irq(tx_irq), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pull-low for bit k of a character carrying d.
    function automatic bit exp_drive(input logic [7:0] d, input int k);
        if (k == 0) return 1'b1;
        if (k <= 8) return ~d[k-1];
        return ~(^d);
    endfunction

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Send one byte that the card rejects nerr times.
    task automatic run_frame(input logic [7:0] d, input int nerr, input bit busy_wr);
        write_byte(d);
        for (int a = 0; a <= nerr; a++) begin
            int w = 0;
            while (!io_drive_low && w < 40 * D) begin
                @(negedge clk);
                w++;
            end
            if (a == 0) chk(w == 0, "R3 start on write", w, 0);
            else chk(w == 2 * D - 3, "R6 resend gap", w, 2 * D - 3);
            for (int c = 0; c <= 12 * D + 2; c++) begin
                card_pull = (a < nerr) && (c >= 10 * D + 1) && (c < 12 * D);
                wr_en = busy_wr && (a == 0) && (c == 3);
                wr_data = ~d;
                if ((c % D) == D / 2 && (c / D) <= 9)
                    chk(io_drive_low == exp_drive(d, c / D), "R2 bit value",
                        io_drive_low, exp_drive(d, c / D));
                if ((c % D) == D / 2 && (c / D) >= 10)
                    chk(!io_drive_low, "R4 guard released", io_drive_low, 0);
                if (c == 5 * D)
                    chk(!tx_end && !hold_empty, "R6 flags low mid-frame", tx_end, 0);
                if (c == 12 * D + 2) begin
                    if (a < nerr) begin
                        err_model = 1'b1;
                        chk(err_flag == 1'b1, "R5 error flag", err_flag, 1);
                        chk(err_irq == err_ie, "R5 error irq", err_irq, err_ie);
                        chk(!tx_end && !hold_empty, "R6 end held", tx_end, 0);
                    end else begin
                        chk(tx_end && hold_empty, "R7 end and empty", tx_end, 1);
                        chk(tx_irq == tx_ie, "R7 tx irq", tx_irq, tx_ie);
                        chk(err_flag == err_model, "R9 flag kept", err_flag, err_model);
                    end
                end
                @(negedge clk);
            end
            card_pull = 1'b0;
            wr_en = 1'b0;
        end
        if (busy_wr) begin
            bit seen = 1'b0;
            for (int c = 0; c < 3 * D; c++) begin
                seen |= io_drive_low;
                @(negedge clk);
            end
            chk(!seen, "R8 busy write ignored", seen, 0);
        end
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        err_model = 1'b0;
        chk(err_flag == 1'b0, "R9 software clear", err_flag, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
        chk(tx_end == 1'b1, "R1 tx_end", tx_end, 1);
        chk(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
        chk(io_drive_low == 1'b0, "R1 line released", io_drive_low, 0);

        tx_ie = 1'b1;
        err_ie = 1'b1;
        D = 8; etu_div = 12'(D);
        run_frame(8'hA5, 0, 1'b0);
        run_frame(8'h00, 1, 1'b1);
        clear_err();
        D = 11; etu_div = 12'(D);
        tx_ie = 1'b0;
        run_frame(8'hFF, 3, 1'b0); // R10 repeated rejections
        clear_err();

        for (int i = 0; i < 16; i++) begin
            D = 8 + int'($urandom_range(0, 12));
            etu_div = 12'(D);
            tx_ie = 1'($urandom_range(0, 1));
            err_ie = 1'($urandom_range(0, 1));
            run_frame(8'($urandom), int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) clear_err();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule